// File: doc/BRIEF.md
# UART Interrupt Source Identification

This block decides which interrupt a 16550-style serial port reports to its host and drives the single interrupt request line. Five conditions can raise an interrupt: a receive line error, a receive character timeout, received data that has reached the threshold, an empty transmit holding register, and a change on the modem control inputs. The block masks each condition with its enable bit and picks the most urgent one. The chosen cause appears as a fixed code in the identification byte.

The block holds two pieces of state. The first is the 4-bit enable register. The second is the "transmit holding empty" pending flag. Register writes set and clear this flag, and a host read of the identification byte that reports that cause also clears it. The serial shifters, the baud generator, the FIFO storage and the modem-status register live in the surrounding UART. They supply their status to this block as plain level inputs.

The identification byte and the interrupt line are registered. Each clock they are recomputed from the current status inputs together with the registered enable and pending state. A change on a status input therefore shows on the outputs one clock later. A write to the enable register shows two clocks later.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, the identification byte reads 0x01, the interrupt line is low, the enable register reads 0 and no transmit-empty cause is pending.
- R2: A write to the enable register keeps only bits [3:0] of the written byte. The stored value is visible on `ien_q`.
- R3: Line error cause. When enable bit 2 is set and any of the four error inputs (overrun, parity, framing, break) is high, the low nibble of the identification byte is 0x6.
- R4: Timeout cause. When the timeout flag is high and enable bit 0 (the receive-data enable) is set, the low nibble is 0xC. No other enable bit allows this cause.
- R5: Receive data cause. With enable bit 0 set and data ready, the low nibble is 0x4. With the FIFO enabled, this cause also requires the FIFO count to be at least the trigger level. With the FIFO disabled, data ready alone is enough.
- R6: Writing the enable register while the holding register is empty sets the transmit-empty pending flag. A holding register write clears the flag and takes precedence over the enable write. With enable bit 1 set, the pending flag gives low nibble 0x2.
- R7: A read of the identification byte clears the transmit-empty pending flag when the byte reports 0x2. A read while the byte reports any other cause leaves the flag set.
- R8: Modem cause. With enable bit 3 set and any of the four modem delta inputs high, the low nibble is 0x0.
- R9: When several causes are active, the byte reports the most urgent one. The order from most to least urgent is: line error, timeout, receive data, transmit empty, modem. With no cause active, the low nibble is 0x1.
- R10: Bits [7:6] of the identification byte read 2'b11 while the FIFO is enabled and 2'b00 otherwise. Bits [5:4] read 0.
- R11: The interrupt line is high exactly when the low nibble is not 0x1.
- R12: The outputs follow a change on a status input one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ien_wr | input | 1 | Enable register write strobe |
| ien_wdata | input | 8 | Byte written to the enable register |
| hold_wr | input | 1 | Transmit holding register write strobe |
| hold_empty | input | 1 | Transmit holding register (or transmit FIFO) is empty |
| id_rd | input | 1 | Host read strobe of the identification byte |
| fifo_on | input | 1 | FIFO mode enabled |
| line_err | input | 4 | Overrun, parity, framing and break error bits |
| rx_ready | input | 1 | Receive data ready |
| rx_level | input | CNT_W | Receive FIFO fill count |
| rx_thresh | input | CNT_W | Receive trigger level |
| rx_stale | input | 1 | Character timeout pending |
| mdm_delta | input | 4 | Modem input change bits |
| ien_q | output | 4 | Stored enable register |
| ident | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
A table of input patterns covers each cause on its own, both with its enable bit and without it. The table separates the timeout cause from the error enable, so a design that gates the timeout with the wrong bit is caught. Receive data is tried with the count one below the trigger and equal to it, and in FIFO-off mode with the count ignored. Mixed patterns check the priority order and the top bits in both FIFO modes. Directed sequences check the pending flag: it is set by an enable write and cleared by a holding write, and a read of the identification byte clears it only while 0x2 is reported.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int NSRC = 5;

   // Cause index, most urgent first.
   typedef enum logic [2:0] {
      SRC_LINE  = 3'd0,
      SRC_STALE = 3'd1,
      SRC_RXDAT = 3'd2,
      SRC_HOLD  = 3'd3,
      SRC_MDM   = 3'd4
   } src_e;

   localparam logic [3:0] ID_NONE  = 4'h1;
   localparam logic [3:0] ID_LINE  = 4'h6;
   localparam logic [3:0] ID_STALE = 4'hC;
   localparam logic [3:0] ID_RXDAT = 4'h4;
   localparam logic [3:0] ID_HOLD  = 4'h2;
   localparam logic [3:0] ID_MDM   = 4'h0;

   function automatic logic [3:0] src_code(input int idx);
      case (idx)
         0:       return ID_LINE;
         1:       return ID_STALE;
         2:       return ID_RXDAT;
         3:       return ID_HOLD;
         default: return ID_MDM;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src
   import uart_irq_pkg::*;
#(
   parameter int CNT_W        = 5,
   parameter bit FIFO_PRESENT = 1'b1
) (
   input  logic [3:0]       ien,
   input  logic [3:0]       line_err,
   input  logic             rx_ready,
   input  logic             fifo_on,
   input  logic [CNT_W-1:0] rx_level,
   input  logic [CNT_W-1:0] rx_thresh,
   input  logic             rx_stale,
   input  logic             hold_pend,
   input  logic [3:0]       mdm_delta,
   output logic [NSRC-1:0]  req
);

   logic rx_hit;

   generate
      if (FIFO_PRESENT) begin : g_fifo
         assign rx_hit = rx_ready && (!fifo_on || (rx_level >= rx_thresh));
      end else begin : g_nofifo
         logic unused_fifo;
         assign unused_fifo = fifo_on ^ (^rx_level) ^ (^rx_thresh);
         assign rx_hit = rx_ready;
      end
   endgenerate

   always_comb begin
      req            = '0;
      req[SRC_LINE]  = ien[2] && (|line_err);
      req[SRC_STALE] = ien[0] && rx_stale;
      req[SRC_RXDAT] = ien[0] && rx_hit;
      req[SRC_HOLD]  = ien[1] && hold_pend;
      req[SRC_MDM]   = ien[3] && (|mdm_delta);
   end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
(
   input  logic [NSRC-1:0] req,
   output logic [3:0]      code
);

   logic [NSRC-1:0] grant;
   logic [NSRC:0]   taken;
   logic [3:0]      part [NSRC+1];

   assign taken[0] = 1'b0;
   assign part[0]  = 4'h0;

   genvar i;
   generate
      for (i = 0; i < NSRC; i++) begin : g_slot
         assign grant[i]   = req[i] && !taken[i];
         assign taken[i+1] = taken[i] || req[i];
         assign part[i+1]  = part[i] | (grant[i] ? src_code(i) : 4'h0);
      end
   endgenerate

   assign code = taken[NSRC] ? part[NSRC] : ID_NONE;

endmodule

// File: rtl/uart_irq_hold_track.sv
module uart_irq_hold_track (
   input  logic clk,
   input  logic rst_n,
   input  logic ien_wr,
   input  logic hold_wr,
   input  logic hold_empty,
   input  logic id_rd,
   input  logic showing_hold,
   output logic hold_pend
);

   always_ff @(posedge clk) begin
      if (!rst_n)                        hold_pend <= 1'b0;
      else if (hold_wr)                  hold_pend <= 1'b0;
      else if (ien_wr && hold_empty)     hold_pend <= 1'b1;
      else if (id_rd && showing_hold)    hold_pend <= 1'b0;
   end

   // R6: a holding write always drops the flag
   a_r6_hold_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      hold_wr |=> !hold_pend);

   // R6: enable write with empty holding register raises the flag
   a_r6_ien_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_wr && hold_empty && !hold_wr) |=> hold_pend);

   // R7: reading the byte while it shows the empty cause clears it
   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (id_rd && showing_hold && !ien_wr) |=> !hold_pend);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int FIFO_DEPTH   = 16,
   parameter bit FIFO_PRESENT = 1'b1,
   localparam int CNT_W       = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ien_wr,
   input  logic [7:0]       ien_wdata,
   input  logic             hold_wr,
   input  logic             hold_empty,
   input  logic             id_rd,
   input  logic             fifo_on,
   input  logic [3:0]       line_err,
   input  logic             rx_ready,
   input  logic [CNT_W-1:0] rx_level,
   input  logic [CNT_W-1:0] rx_thresh,
   input  logic             rx_stale,
   input  logic [3:0]       mdm_delta,
   output logic [3:0]       ien_q,
   output logic [7:0]       ident,
   output logic             irq
);

   generate
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 1");
      end
   endgenerate

   logic [NSRC-1:0] req;
   logic [3:0]      code;
   logic            hold_pend;
   logic [1:0]      top_bits;

   always_ff @(posedge clk) begin
      if (!rst_n)      ien_q <= 4'h0;
      else if (ien_wr) ien_q <= ien_wdata[3:0];
   end

   uart_irq_hold_track u_hold (
      .clk          (clk),
      .rst_n        (rst_n),
      .ien_wr       (ien_wr),
      .hold_wr      (hold_wr),
      .hold_empty   (hold_empty),
      .id_rd        (id_rd),
      .showing_hold (ident[3:0] == ID_HOLD),
      .hold_pend    (hold_pend)
   );

   uart_irq_src #(.CNT_W(CNT_W), .FIFO_PRESENT(FIFO_PRESENT)) u_src (
      .ien       (ien_q),
      .line_err  (line_err),
      .rx_ready  (rx_ready),
      .fifo_on   (fifo_on),
      .rx_level  (rx_level),
      .rx_thresh (rx_thresh),
      .rx_stale  (rx_stale),
      .hold_pend (hold_pend),
      .mdm_delta (mdm_delta),
      .req       (req)
   );

   uart_irq_prio u_prio (
      .req  (req),
      .code (code)
   );

   generate
      if (FIFO_PRESENT) begin : g_top_fifo
         assign top_bits = {2{fifo_on}};
      end else begin : g_top_plain
         assign top_bits = 2'b00;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ident <= {4'h0, ID_NONE};
         irq   <= 1'b0;
      end else begin
         ident <= {top_bits, 2'b00, code};
         irq   <= (code != ID_NONE);
      end
   end

   a_r2_ien_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
      ien_wr |=> (ien_q == $past(ien_wdata[3:0])));

   a_r3_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q[2] && (|line_err)) |=> (ident[3:0] == 4'h6));

   a_r10_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (FIFO_PRESENT && fifo_on) |=> (ident[7:6] == 2'b11));

   a_r11_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (ident[3:0] != 4'h1));

endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;

   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ien_wr = 1'b0;
   logic [7:0]    ien_wdata = 8'h0;
   logic          hold_wr = 1'b0;
   logic          hold_empty = 1'b0;
   logic          id_rd = 1'b0;
   logic          fifo_on = 1'b0;
   logic [3:0]    line_err = 4'h0;
   logic          rx_ready = 1'b0;
   logic [CW-1:0] rx_level = '0;
   logic [CW-1:0] rx_thresh = '0;
   logic          rx_stale = 1'b0;
   logic [3:0]    mdm_delta = 4'h0;
   logic [3:0]    ien_q;
   logic [7:0]    ident;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   uart_irq_ident u0 (
      .clk(clk), .rst_n(rst_n), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
      .hold_wr(hold_wr), .hold_empty(hold_empty), .id_rd(id_rd),
      .fifo_on(fifo_on), .line_err(line_err), .rx_ready(rx_ready),
      .rx_level(rx_level), .rx_thresh(rx_thresh), .rx_stale(rx_stale),
      .mdm_delta(mdm_delta), .ien_q(ien_q), .ident(ident), .irq(irq)
   );

   typedef struct packed {
      logic [3:0]    ie;
      logic [3:0]    err;
      logic          dr;
      logic          fen;
      logic [CW-1:0] cnt;
      logic [CW-1:0] trg;
      logic          to;
      logic [3:0]    md;
      logic [7:0]    exp_id;
   } vec_t;

   localparam int NV = 14;
   // R3 R4 R5 R8 R9 R10 R11 R12 patterns
   localparam vec_t VT [NV] = '{
      '{4'hF, 4'h0, 1'b0, 1'b0, 5'd0, 5'd1, 1'b0, 4'h0, 8'h01},
      '{4'h4, 4'h1, 1'b0, 1'b0, 5'd0, 5'd1, 1'b0, 4'h0, 8'h06},
      '{4'h0, 4'h1, 1'b0, 1'b0, 5'd0, 5'd1, 1'b0, 4'h0, 8'h01},
      '{4'h1, 4'h0, 1'b0, 1'b1, 5'd0, 5'd1, 1'b1, 4'h0, 8'hCC},
      '{4'h4, 4'h0, 1'b0, 1'b1, 5'd0, 5'd1, 1'b1, 4'h0, 8'hC1},
      '{4'h1, 4'h0, 1'b1, 1'b1, 5'd3, 5'd4, 1'b0, 4'h0, 8'hC1},
      '{4'h1, 4'h0, 1'b1, 1'b1, 5'd4, 5'd4, 1'b0, 4'h0, 8'hC4},
      '{4'h1, 4'h0, 1'b1, 1'b0, 5'd0, 5'd8, 1'b0, 4'h0, 8'h04},
      '{4'h8, 4'h0, 1'b0, 1'b0, 5'd0, 5'd1, 1'b0, 4'h4, 8'h00},
      '{4'hF, 4'h8, 1'b1, 1'b0, 5'd0, 5'd1, 1'b1, 4'h1, 8'h06},
      '{4'hB, 4'h2, 1'b1, 1'b0, 5'd0, 5'd1, 1'b1, 4'h1, 8'h0C},
      '{4'h9, 4'h0, 1'b1, 1'b0, 5'd0, 5'd1, 1'b0, 4'h1, 8'h04},
      '{4'h8, 4'h0, 1'b0, 1'b1, 5'd0, 5'd1, 1'b0, 4'h8, 8'hC0},
      '{4'h7, 4'h0, 1'b0, 1'b0, 5'd0, 5'd1, 1'b0, 4'hF, 8'h01}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
      #1;
   endtask

   task automatic clear_status();
      @(negedge clk);
      line_err = 4'h0; rx_ready = 1'b0; rx_stale = 1'b0; mdm_delta = 4'h0;
      fifo_on = 1'b0; rx_level = '0; rx_thresh = 5'd1;
   endtask

   task automatic write_ien(input logic [7:0] v, input logic empty);
      @(negedge clk);
      ien_wdata = v; ien_wr = 1'b1; hold_empty = empty;
      @(negedge clk);
      ien_wr = 1'b0;
   endtask

   task automatic pulse_read();
      @(negedge clk);
      id_rd = 1'b1;
      @(negedge clk);
      id_rd = 1'b0;
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      tick(3);
      // R1 reset state
      chk("R1 ident", {24'h0, ident}, 32'h01);
      chk("R1 irq", {31'h0, irq}, 32'h0);
      chk("R1 ien", {28'h0, ien_q}, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         ien_wr = 1'b1; ien_wdata = {4'h0, VT[v].ie}; hold_empty = 1'b0;
         line_err = VT[v].err; rx_ready = VT[v].dr; fifo_on = VT[v].fen;
         rx_level = VT[v].cnt; rx_thresh = VT[v].trg; rx_stale = VT[v].to;
         mdm_delta = VT[v].md;
         @(negedge clk); ien_wr = 1'b0;
         tick(1);
         chk($sformatf("R9 vector %0d ident", v), {24'h0, ident}, {24'h0, VT[v].exp_id});
         chk($sformatf("R11 vector %0d irq", v), {31'h0, irq},
             {31'h0, VT[v].exp_id[3:0] != 4'h1});
      end

      // R2 upper bits dropped
      clear_status();
      write_ien(8'hF3, 1'b0);
      chk("R2 ien low nibble", {28'h0, ien_q}, 32'h3);

      // R12 one-clock response to a status input
      @(negedge clk); mdm_delta = 4'h0;
      write_ien(8'h08, 1'b0);
      @(negedge clk); mdm_delta = 4'h2;
      tick(1);
      chk("R12 one clock latency", {24'h0, ident}, 32'h00);

      // R6 enable write with empty holding register sets pending
      clear_status();
      write_ien(8'h02, 1'b1);
      tick(1);
      chk("R6 pending shows 0x2", {24'h0, ident}, 32'h02);
      // R7 read while reporting 0x2 clears it
      pulse_read();
      tick(1);
      chk("R7 read clears pending", {24'h0, ident}, 32'h01);

      // R6 holding write clears pending
      write_ien(8'h02, 1'b1);
      @(negedge clk); hold_wr = 1'b1;
      @(negedge clk); hold_wr = 1'b0;
      tick(1);
      chk("R6 holding write clears", {24'h0, ident}, 32'h01);

      // R7 read while another cause shown keeps pending
      write_ien(8'h03, 1'b1);
      @(negedge clk); rx_ready = 1'b1;
      tick(1);
      chk("R7 rx data outranks empty", {24'h0, ident}, 32'h04);
      pulse_read();
      @(negedge clk); rx_ready = 1'b0;
      tick(1);
      chk("R7 pending survives other read", {24'h0, ident}, 32'h02);

      // R9 transmit empty outranks modem
      write_ien(8'h0A, 1'b1);
      @(negedge clk); mdm_delta = 4'h8;
      tick(1);
      chk("R9 empty over modem", {24'h0, ident}, 32'h02);
      pulse_read();
      tick(1);
      chk("R8 modem after empty read", {24'h0, ident}, 32'h00);

      // R10 top bits with FIFO on and nothing pending
      clear_status();
      write_ien(8'h00, 1'b0);
      @(negedge clk); fifo_on = 1'b1;
      tick(1);
      chk("R10 fifo bits", {24'h0, ident}, 32'hC1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule